// File: doc/BRIEF.md
# PWM Time-Base Counter with Shadowed Period

This block is the time base for a pulse-width modulator. It holds a 16-bit count, by default, that either falls from the period value down to zero and reloads, or climbs from zero to the period value and falls back again. Two single-cycle event flags come out of it. One flags that the count equals the active period. The other flags that the count is zero. Downstream waveform generators, interrupt logic and converter triggers use these flags.

The period is double-buffered. A write strobe places a new value in a shadow register. The active period changes only on a clock edge at which the count is zero. In local update mode, the first such edge after the write commits the value. In global update mode, the block also waits for a global-update request strobe. A second write before the commit replaces the pending value, so the first value is never used. A build parameter can remove the global-request logic entirely, and the block then always behaves as in local mode.

Top module: `pwm_timebase`

## Requirements
- R1: While `rst` is high at a rising edge, the next state has `count` = 0 and `period` = 0. With period 0, both `evt_zero` and `evt_match` read 1.
- R2: With `mode_updown` = 0 (down mode) and `en` = 1, an edge taken at count 0 loads the active period into the count. Any other edge decrements the count, so the sequence is P, P-1, ..., 0, P.
- R3: With `mode_updown` = 1 and `en` = 1, the count follows 0, 1, ..., P, P-1, ..., 1, 0, 1, and so on. The count never exceeds the active period in either mode.
- R4: `evt_match` is 1 in exactly those cycles in which `count` equals `period`.
- R5: `evt_zero` is 1 in exactly those cycles in which `count` is 0.
- R6: With `upd_global` = 0, a value written with `wr_en` becomes `period` at the first later rising edge taken while the count is 0. In down mode, that same edge reloads the count with the new value. Until then, `period` is unchanged.
- R7: With `upd_global` = 1, a pending value is committed only at a count-0 edge that comes after a `gupd_req` pulse. Zero edges before the request leave it pending. The latched request is consumed by the commit, so a later write needs a new request.
- R8: A write while a value is still pending replaces the pending value. The replaced value never appears on `period`.
- R9: With `en` = 0, the count and the up/down direction hold. A pending commit still happens at a count-0 edge.
- R10: An active period of 0 keeps the count at 0 in both modes, and `evt_zero` and `evt_match` are both 1 in every cycle.
- R11: `period` changes only on an edge taken while the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Counter enable; counting holds while low |
| mode_updown | input | 1 | 0: down counting with reload; 1: up/down counting |
| upd_global | input | 1 | 0: commit at next zero; 1: commit at next zero after a global request |
| wr_en | input | 1 | Write strobe for the shadow period |
| wr_data | input | 16 | New period value |
| gupd_req | input | 1 | Global update request strobe |
| count | output | 16 | Current count |
| period | output | 16 | Active period value |
| evt_match | output | 1 | Count equals active period |
| evt_zero | output | 1 | Count equals zero |

## Verification
The hardest case to reach from the ports is a pending value in global mode that must survive a zero crossing without being committed. The bench therefore writes a new period while global mode is selected and lets one full cycle pass with no request. It checks that the old period reloads, and only then pulses the request.

After the commit it writes again with no request and crosses zero. This shows that the latched request was used up. The replaced-write case is set up with two writes on consecutive edges in the middle of a countdown, so that both writes land before the next zero.

// File: rtl/pwm_tbase_pkg.sv
package pwm_tbase_pkg;

   typedef enum logic {
      MODE_DOWN   = 1'b0,
      MODE_UPDOWN = 1'b1
   } cnt_mode_e;

   typedef enum logic [1:0] {
      STEP_HOLD   = 2'd0,
      STEP_RELOAD = 2'd1,
      STEP_INC    = 2'd2,
      STEP_DEC    = 2'd3
   } cnt_step_e;

endpackage

// File: rtl/pwm_period_buf.sv
module pwm_period_buf #(
   parameter int W          = 16,
   parameter bit HAS_GLOBAL = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         at_zero,
   input  logic         upd_global,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         gupd_req,
   output logic [W-1:0] period_q,
   output logic [W-1:0] period_nxt
);

   logic [W-1:0] shadow_q;
   logic         pend_q;
   logic         gate;
   logic         commit;

   // Request gating: a generate variant with or without the global path.
   if (HAS_GLOBAL) begin : g_global
      logic greq_q;
      always_ff @(posedge clk) begin
         if (rst) greq_q <= 1'b0;
         else     greq_q <= (greq_q & ~commit) | gupd_req;
      end
      assign gate = upd_global ? greq_q : 1'b1;
   end else begin : g_local_only
      logic unused_global;
      assign unused_global = upd_global ^ gupd_req;
      assign gate = 1'b1;
   end

   assign commit     = pend_q & at_zero & gate;
   assign period_nxt = commit ? shadow_q : period_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         shadow_q <= '0;
         pend_q   <= 1'b0;
         period_q <= '0;
      end else begin
         period_q <= period_nxt;
         pend_q   <= wr_en | (pend_q & ~commit);
         if (wr_en) shadow_q <= wr_data;
      end
   end

endmodule

// File: rtl/pwm_evt_decode.sv
module pwm_evt_decode #(
   parameter int W = 16
) (
   input  logic [W-1:0] count,
   input  logic [W-1:0] period,
   output logic         evt_zero,
   output logic         evt_match
);

   assign evt_zero  = (count == '0);
   assign evt_match = (count == period);

endmodule

// File: rtl/pwm_tbase_core.sv
module pwm_tbase_core
   import pwm_tbase_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic         mode_updown,
   input  logic         at_zero,
   input  logic [W-1:0] period_nxt,
   output logic [W-1:0] count_q
);

   localparam logic [W-1:0] ONE = W'(1);

   cnt_mode_e    mode;
   cnt_step_e    step;
   logic         dir_up_q;
   logic         dir_up_d;
   logic [W-1:0] reload_val;

   assign mode = cnt_mode_e'(mode_updown);

   always_comb begin
      if (mode == MODE_DOWN)     reload_val = period_nxt;
      else if (period_nxt == '0) reload_val = '0;
      else                       reload_val = ONE;
   end

   always_comb begin
      step     = STEP_HOLD;
      dir_up_d = dir_up_q;
      if (en) begin
         if (at_zero) begin
            step     = STEP_RELOAD;
            dir_up_d = 1'b1;
         end else if (mode == MODE_DOWN) begin
            step = STEP_DEC;
         end else if (dir_up_q && (count_q < period_nxt)) begin
            step = STEP_INC;
         end else begin
            step     = STEP_DEC;
            dir_up_d = 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         count_q  <= '0;
         dir_up_q <= 1'b1;
      end else begin
         dir_up_q <= dir_up_d;
         unique case (step)
            STEP_RELOAD: count_q <= reload_val;
            STEP_INC:    count_q <= count_q + ONE;
            STEP_DEC:    count_q <= count_q - ONE;
            default:     count_q <= count_q;
         endcase
      end
   end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
   parameter int CNT_W      = 16,
   parameter bit HAS_GLOBAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             mode_updown,
   input  logic             upd_global,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             gupd_req,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] period,
   output logic             evt_match,
   output logic             evt_zero
);

   if (CNT_W < 2) begin : g_bad_width
      $error("pwm_timebase: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] period_nxt;

   pwm_evt_decode #(.W(CNT_W)) u_dec (
      .count     (count),
      .period    (period),
      .evt_zero  (evt_zero),
      .evt_match (evt_match)
   );

   pwm_period_buf #(.W(CNT_W), .HAS_GLOBAL(HAS_GLOBAL)) u_buf (
      .clk        (clk),
      .rst        (rst),
      .at_zero    (evt_zero),
      .upd_global (upd_global),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .gupd_req   (gupd_req),
      .period_q   (period),
      .period_nxt (period_nxt)
   );

   pwm_tbase_core #(.W(CNT_W)) u_core (
      .clk         (clk),
      .rst         (rst),
      .en          (en),
      .mode_updown (mode_updown),
      .at_zero     (evt_zero),
      .period_nxt  (period_nxt),
      .count_q     (count)
   );

endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             en,
   input logic             mode_updown,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] period,
   input logic             evt_match,
   input logic             evt_zero
);

   logic rst_q;
   always_ff @(posedge clk) rst_q <= rst;

   always @(negedge clk) begin
      if (rst_q === 1'b1) begin
         a_r1_reset_state: assert (count == '0 && period == '0);
      end
   end

   a_r2_reload: assert property (@(posedge clk) disable iff (rst)
      (!mode_updown && en && evt_zero) |=> (count == period));

   a_r2_decrement: assert property (@(posedge clk) disable iff (rst)
      (!mode_updown && en && !evt_zero) |=> (count == $past(count) - CNT_W'(1)));

   a_r3_within_period: assert property (@(posedge clk) disable iff (rst)
      count <= period);

   a_r9_hold: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(count));

   a_r10_zero_period: assert property (@(posedge clk) disable iff (rst)
      (period == '0) |-> (evt_zero && evt_match));

   a_r11_commit_at_zero: assert property (@(posedge clk) disable iff (rst)
      !evt_zero |=> $stable(period));

endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_pwm_timebase.sv
module tb_pwm_timebase;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        en = 1'b0;
   logic        mode_updown = 1'b0;
   logic        upd_global = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic        gupd_req = 1'b0;
   logic [15:0] count;
   logic [15:0] period;
   logic        evt_match;
   logic        evt_zero;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   pwm_timebase dut (
      .clk(clk), .rst(rst), .en(en), .mode_updown(mode_updown),
      .upd_global(upd_global), .wr_en(wr_en), .wr_data(wr_data),
      .gupd_req(gupd_req), .count(count), .period(period),
      .evt_match(evt_match), .evt_zero(evt_zero)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic expect_state(input string req, input int c, input int p,
                               input int m, input int z);
      check({req, " count"}, int'(count), c);
      check({req, " period"}, int'(period), p);
      check("R4 evt_match", int'(evt_match), m);
      check("R5 evt_zero", int'(evt_zero), z);
   endtask

   task automatic write_step(input int v);
      wr_en = 1'b1;
      wr_data = 16'(v);
      step();
      wr_en = 1'b0;
   endtask

   task automatic t_reset();
      rst = 1'b1; en = 1'b0; wr_en = 1'b0; gupd_req = 1'b0;
      step(); step();
      rst = 1'b0;
      expect_state("R1 reset", 0, 0, 1, 1);
   endtask

   // Down mode, local commit while disabled, then counting and events.
   task automatic t_down_basic();
      mode_updown = 1'b0; upd_global = 1'b0;
      write_step(3);
      expect_state("R9 before commit", 0, 0, 1, 1);
      step();
      expect_state("R9 commit while disabled", 0, 3, 0, 1);
      en = 1'b1;
      step(); expect_state("R2 reload", 3, 3, 1, 0);
      step(); expect_state("R2 dec", 2, 3, 0, 0);
      step(); expect_state("R2 dec", 1, 3, 0, 0);
      step(); expect_state("R2 zero", 0, 3, 0, 1);
      step(); expect_state("R2 reload again", 3, 3, 1, 0);
   endtask

   // Local update waits for the zero edge.
   task automatic t_local_update();
      write_step(5);
      expect_state("R6 pending", 2, 3, 0, 0);
      step(); expect_state("R6 pending", 1, 3, 0, 0);
      step(); expect_state("R6 pending at zero", 0, 3, 0, 1);
      step(); expect_state("R6 committed", 5, 5, 1, 0);
   endtask

   // Two writes before the zero: only the second is used.
   task automatic t_overwrite();
      write_step(7);
      expect_state("R8 first write", 4, 5, 0, 0);
      write_step(2);
      expect_state("R8 second write", 3, 5, 0, 0);
      step(); step(); step();
      expect_state("R8 at zero", 0, 5, 0, 1);
      step();
      expect_state("R8 newest value", 2, 2, 1, 0);
   endtask

   // Global mode: no commit without a request; request consumed on commit.
   task automatic t_global();
      upd_global = 1'b1;
      write_step(4);
      check("R7 count", int'(count), 1);
      step();
      step();
      expect_state("R7 no request keeps old", 2, 2, 1, 0);
      gupd_req = 1'b1;
      step();
      gupd_req = 1'b0;
      check("R7 after request", int'(count), 1);
      step();
      expect_state("R7 zero before commit", 0, 2, 0, 1);
      step();
      expect_state("R7 committed", 4, 4, 1, 0);
      write_step(6);
      step(); step(); step();
      expect_state("R7 request consumed zero", 0, 4, 0, 1);
      step();
      expect_state("R7 request consumed", 4, 4, 1, 0);
      upd_global = 1'b0;
   endtask

   // Up/down sequence, hold, and zero period.
   task automatic t_updown();
      mode_updown = 1'b1; upd_global = 1'b0;
      write_step(3);
      step();
      expect_state("R3 committed", 0, 3, 0, 1);
      en = 1'b1;
      step(); expect_state("R3 up", 1, 3, 0, 0);
      step(); expect_state("R3 up", 2, 3, 0, 0);
      step(); expect_state("R3 top", 3, 3, 1, 0);
      step(); expect_state("R3 down", 2, 3, 0, 0);
      step(); expect_state("R3 down", 1, 3, 0, 0);
      step(); expect_state("R3 bottom", 0, 3, 0, 1);
      step(); expect_state("R3 up again", 1, 3, 0, 0);
      step(); expect_state("R3 up again", 2, 3, 0, 0);
      en = 1'b0;
      for (int i = 0; i < 3; i++) begin
         step();
         check("R9 hold", int'(count), 2);
      end
      en = 1'b1;
      step();
      expect_state("R9 direction kept", 3, 3, 1, 0);
      write_step(0);
      step(); step();
      expect_state("R10 before commit", 0, 3, 0, 1);
      for (int i = 0; i < 4; i++) begin
         step();
         expect_state("R10 zero period", 0, 0, 1, 1);
      end
   endtask

   task automatic t_zero_period_down();
      mode_updown = 1'b0;
      for (int i = 0; i < 3; i++) begin
         step();
         expect_state("R10 down mode", 0, 0, 1, 1);
      end
   endtask

   initial begin
      t_reset();
      t_down_basic();
      t_local_update();
      t_overwrite();
      t_global();
      t_reset();
      t_updown();
      t_zero_period_down();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule